// File: doc/BRIEF.md
# Modulator Fail-Safe Output Sequencer

This block produces the one-bit serial output of an isolated delta-sigma modulator. One bit leaves on every edge of the modulator clock. When the part is healthy, the output passes the bit from the modulator loop through unchanged. When a fault is present, the block substitutes a fixed signature that a downstream filter can recognise. These substitutes cover five conditions:

- loss of the supply
- the interface test pattern that follows supply return
- common-mode overvoltage
- clipping at the negative input limit
- clipping at the positive input limit

The conditions are resolved in a fixed priority, and every forced value is registered on the clock edge. A debug code on a separate output reports which condition won on each edge.

The output stream is free-running. The bit rate is set by the modulator clock, so the block has no ready input and nothing downstream can hold it back. Instead, `dout_valid` qualifies each bit. It stays low while the supply is missing and for the first `ASTART_CYC` bits after the supply returns, which models the analog settling time. A receiver discards bits whose valid is low. It may still read the signature bits from the fault states, because those carry meaning.

Top module: `mod_failsafe_seq`

## Requirements
- R1: On an edge where `supply_ok` is 0, the next `dout` is 0, `state_dbg` is 0 (no supply) and `dout_valid` is 0. This holds whatever the other inputs are.
- R2: Once `supply_ok` has returned, the first 32 output bits alternate and start with 0. During these bits `state_dbg` is 1 (startup).
- R3: The startup pattern wins over overvoltage and over both clip flags.
- R4: After the startup pattern, if `cm_ovr` is 1 on an edge, the next `dout` is 1 and `state_dbg` is 2 (overvoltage). Overvoltage wins over both clip flags.
- R5: After the startup pattern, if no fault flag is set on an edge, the next `dout` equals `mod_bit` sampled on that edge, and `state_dbg` is 5 (normal).
- R6: While negative clipping is selected (`state_dbg` 3), the output repeats a frame of 127 zeros followed by a run of ones.
- R7: While positive clipping is selected (`state_dbg` 4), the output repeats a frame of 127 ones followed by a run of zeros.
- R8: The run length is set by `drive_lvl`: 0 gives 1 bit, 1 gives 2 bits, and 2 gives 3 bits. A value of 3 is treated as 2 and also gives 3 bits.
- R9: The clip frame starts again at position 0, the first bit of the 127-bit fill, when clipping is entered from another state and whenever the clip polarity changes.
- R10: When `clip_neg` and `clip_pos` are both 1, negative clipping is selected.
- R11: After the supply returns, the output bits are numbered from 0. `dout_valid` is 1 for bit k exactly when k >= `ASTART_CYC` and the supply is still good.
- R12: Every output is registered and changes only one edge after the inputs that cause it. During reset `dout` = 0, `state_dbg` = 0 and `dout_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock; one output bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | High-side supply present |
| cm_ovr | input | 1 | Common-mode overvoltage flag |
| clip_neg | input | 1 | Input beyond negative clipping level |
| clip_pos | input | 1 | Input beyond positive clipping level |
| drive_lvl | input | 2 | Overdrive code selecting the clip run length |
| mod_bit | input | 1 | Bit from the delta-sigma loop |
| dout | output | 1 | Serial output bit |
| dout_valid | output | 1 | Qualifies `dout` as a settled conversion bit |
| state_dbg | output | 3 | Winning condition: 0 no supply, 1 startup, 2 overvoltage, 3 negative clip, 4 positive clip, 5 normal |

## Verification
The assertions check the following on every edge:

- forcing to 0 during supply loss
- the alternating startup bits
- the constant 1 under overvoltage
- pass-through of the loop bit
- negative clipping winning when both clip flags are set
- the timing of `dout_valid`, measured against an independent count of the edges since the supply came back

The clip signatures can only be shown by the bench scenarios. These cover the 127-bit fill and the tail run at each drive code, the saturating fourth code, and a frame restart on a polarity change made mid-frame. The bench also drops the supply during clipping and then runs the restart that follows.

// File: rtl/mfs_pkg.sv
package mfs_pkg;

  // Debug state codes, listed from highest to lowest priority except NORMAL.
  typedef enum logic [2:0] {
    ST_NO_SUPPLY = 3'd0,
    ST_STARTUP   = 3'd1,
    ST_OVERVOLT  = 3'd2,
    ST_CLIP_NEG  = 3'd3,
    ST_CLIP_POS  = 3'd4,
    ST_NORMAL    = 3'd5
  } mfs_state_e;

  // Clip polarity seen by the frame generator.
  typedef enum logic [1:0] {
    POL_NONE = 2'd0,
    POL_NEG  = 2'd1,
    POL_POS  = 2'd2
  } mfs_pol_e;

endpackage

// File: rtl/mfs_startup_timer.sv
module mfs_startup_timer #(
  parameter int PAT_LEN    = 32,
  parameter int ASTART_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic in_pattern,
  output logic pat_bit,
  output logic settled
);
  localparam int CW = $clog2(ASTART_CYC + 1);
  localparam logic [CW-1:0] SAT_V = CW'(ASTART_CYC);
  localparam logic [CW-1:0] PAT_V = CW'(PAT_LEN);

  // Counts edges since supply return, saturating at the settling length.
  logic [CW-1:0] up_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_cnt <= '0;
    end else if (!supply_ok) begin
      up_cnt <= '0;
    end else if (up_cnt != SAT_V) begin
      up_cnt <= up_cnt + CW'(1);
    end
  end

  assign in_pattern = supply_ok && (up_cnt < PAT_V);
  assign pat_bit    = up_cnt[0];
  assign settled    = supply_ok && (up_cnt == SAT_V);

endmodule

// File: rtl/mfs_priority_sel.sv
module mfs_priority_sel
  import mfs_pkg::*;
(
  input  logic       supply_ok,
  input  logic       in_pattern,
  input  logic       cm_ovr,
  input  logic       clip_neg,
  input  logic       clip_pos,
  output mfs_state_e sel_state,
  output mfs_pol_e   sel_pol
);
  always_comb begin
    sel_pol = POL_NONE;
    if (!supply_ok) begin
      sel_state = ST_NO_SUPPLY;
    end else if (in_pattern) begin
      sel_state = ST_STARTUP;
    end else if (cm_ovr) begin
      sel_state = ST_OVERVOLT;
    end else if (clip_neg) begin
      sel_state = ST_CLIP_NEG;
      sel_pol   = POL_NEG;
    end else if (clip_pos) begin
      sel_state = ST_CLIP_POS;
      sel_pol   = POL_POS;
    end else begin
      sel_state = ST_NORMAL;
    end
  end

endmodule

// File: rtl/mfs_clip_framer.sv
module mfs_clip_framer
  import mfs_pkg::*;
#(
  parameter int FILL_LEN = 127,
  parameter int MAX_RUN  = 3,
  parameter int LVL_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mfs_pol_e         pol,
  input  logic [LVL_W-1:0] lvl,
  output logic             frame_bit
);
  localparam int FW = $clog2(FILL_LEN + MAX_RUN + 1);

  logic [FW-1:0] fr_cnt;
  logic [FW-1:0] idx;
  logic [FW-1:0] nxt_idx;
  mfs_pol_e      last_pol;
  int            run_len;
  logic          in_tail;
  logic          wrap;

  // Overdrive code to tail length, saturating at MAX_RUN.
  always_comb begin
    if (int'(lvl) >= MAX_RUN - 1) run_len = MAX_RUN;
    else                          run_len = int'(lvl) + 1;
  end

  always_comb begin
    idx       = (pol == last_pol) ? fr_cnt : '0;
    in_tail   = int'(idx) >= FILL_LEN;
    wrap      = (int'(idx) + 1) >= (FILL_LEN + run_len);
    nxt_idx   = wrap ? '0 : idx + FW'(1);
    frame_bit = (pol == POL_NEG) ? in_tail : !in_tail;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_cnt   <= '0;
      last_pol <= POL_NONE;
    end else if (pol == POL_NONE) begin
      fr_cnt   <= '0;
      last_pol <= POL_NONE;
    end else begin
      fr_cnt   <= nxt_idx;
      last_pol <= pol;
    end
  end

endmodule

// File: rtl/mod_failsafe_seq.sv
module mod_failsafe_seq
  import mfs_pkg::*;
#(
  parameter int PAT_LEN    = 32,
  parameter int ASTART_CYC = 10000,
  parameter int FILL_LEN   = 127,
  parameter int MAX_RUN    = 3,
  parameter int LVL_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             cm_ovr,
  input  logic             clip_neg,
  input  logic             clip_pos,
  input  logic [LVL_W-1:0] drive_lvl,
  input  logic             mod_bit,
  output logic             dout,
  output logic             dout_valid,
  output logic [2:0]       state_dbg
);
  logic       in_pattern;
  logic       pat_bit;
  logic       settled;
  logic       frame_bit;
  logic       dout_d;
  mfs_state_e sel_state;
  mfs_pol_e   sel_pol;
  mfs_state_e state_q;

  mfs_startup_timer #(
    .PAT_LEN   (PAT_LEN),
    .ASTART_CYC(ASTART_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .in_pattern(in_pattern),
    .pat_bit   (pat_bit),
    .settled   (settled)
  );

  mfs_priority_sel u_sel (
    .supply_ok (supply_ok),
    .in_pattern(in_pattern),
    .cm_ovr    (cm_ovr),
    .clip_neg  (clip_neg),
    .clip_pos  (clip_pos),
    .sel_state (sel_state),
    .sel_pol   (sel_pol)
  );

  mfs_clip_framer #(
    .FILL_LEN(FILL_LEN),
    .MAX_RUN (MAX_RUN),
    .LVL_W   (LVL_W)
  ) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .pol      (sel_pol),
    .lvl      (drive_lvl),
    .frame_bit(frame_bit)
  );

  always_comb begin
    unique case (sel_state)
      ST_NO_SUPPLY: dout_d = 1'b0;
      ST_STARTUP:   dout_d = pat_bit;
      ST_OVERVOLT:  dout_d = 1'b1;
      ST_CLIP_NEG,
      ST_CLIP_POS:  dout_d = frame_bit;
      default:      dout_d = mod_bit;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout       <= 1'b0;
      dout_valid <= 1'b0;
      state_q    <= ST_NO_SUPPLY;
    end else begin
      dout       <= dout_d;
      dout_valid <= settled;
      state_q    <= sel_state;
    end
  end

  assign state_dbg = state_q;

endmodule

// File: rtl/mfs_checker.sv
module mfs_checker
  import mfs_pkg::*;
#(
  parameter int PAT_LEN    = 32,
  parameter int ASTART_CYC = 10000,
  parameter int LVL_W      = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             supply_ok,
  input logic             cm_ovr,
  input logic             clip_neg,
  input logic             clip_pos,
  input logic [LVL_W-1:0] drive_lvl,
  input logic             mod_bit,
  input logic             dout,
  input logic             dout_valid,
  input logic [2:0]       state_dbg
);
  localparam int KW = $clog2(ASTART_CYC + 1);
  localparam logic [KW-1:0] K_SAT = KW'(ASTART_CYC);
  localparam logic [KW-1:0] K_PAT = KW'(PAT_LEN);

  // Independent count of edges since the supply came back.
  logic [KW-1:0] up_seen;
  logic          past_pat;
  logic          at_sat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               up_seen <= '0;
    else if (!supply_ok)      up_seen <= '0;
    else if (up_seen != K_SAT) up_seen <= up_seen + KW'(1);
  end

  assign past_pat = supply_ok && (up_seen >= K_PAT);
  assign at_sat   = up_seen == K_SAT;

  a_r1_no_supply: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!dout && !dout_valid && state_dbg == ST_NO_SUPPLY));

  a_r2_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && up_seen < K_PAT) |=>
      (dout == $past(up_seen[0]) && state_dbg == ST_STARTUP));

  a_r4_overvolt: assert property (@(posedge clk) disable iff (!rst_n)
    (past_pat && cm_ovr) |=> (dout && state_dbg == ST_OVERVOLT));

  a_r5_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (past_pat && !cm_ovr && !clip_neg && !clip_pos) |=>
      (dout == $past(mod_bit) && state_dbg == ST_NORMAL));

  a_r10_neg_first: assert property (@(posedge clk) disable iff (!rst_n)
    (past_pat && !cm_ovr && clip_neg) |=> (state_dbg == ST_CLIP_NEG));

  a_r11_valid: assert property (@(posedge clk) disable iff (!rst_n)
    supply_ok |=> (dout_valid == $past(at_sat)));

  a_r12_code: assert property (@(posedge clk) disable iff (!rst_n)
    state_dbg <= ST_NORMAL);

endmodule

bind mod_failsafe_seq mfs_checker #(
  .PAT_LEN   (PAT_LEN),
  .ASTART_CYC(ASTART_CYC),
  .LVL_W     (LVL_W)
) u_mfs_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .supply_ok (supply_ok),
  .cm_ovr    (cm_ovr),
  .clip_neg  (clip_neg),
  .clip_pos  (clip_pos),
  .drive_lvl (drive_lvl),
  .mod_bit   (mod_bit),
  .dout      (dout),
  .dout_valid(dout_valid),
  .state_dbg (state_dbg)
);

// File: tb/test_mod_failsafe_seq.sv
module test_mod_failsafe_seq;
  import mfs_pkg::*;

  localparam int ASTART = 48;
  localparam int FILL   = 127;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       supply_ok = 1'b0;
  logic       cm_ovr = 1'b0;
  logic       clip_neg = 1'b0;
  logic       clip_pos = 1'b0;
  logic [1:0] drive_lvl = 2'd0;
  logic       mod_bit = 1'b0;
  logic       dout;
  logic       dout_valid;
  logic [2:0] state_dbg;

  int total = 0;
  int bad   = 0;
  int up    = 0;
  bit done  = 1'b0;

  typedef struct {
    logic       d;
    logic [2:0] st;
    logic       v;
    string      tag;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  mod_failsafe_seq #(.ASTART_CYC(ASTART)) i_mod_failsafe_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .cm_ovr    (cm_ovr),
    .clip_neg  (clip_neg),
    .clip_pos  (clip_pos),
    .drive_lvl (drive_lvl),
    .mod_bit   (mod_bit),
    .dout      (dout),
    .dout_valid(dout_valid),
    .state_dbg (state_dbg)
  );

  // Driver: apply one edge of stimulus, then queue what the next output should be.
  task automatic step(input logic s, input logic ov, input logic cn, input logic cp,
                      input logic [1:0] lv, input logic mb, input logic ed,
                      input mfs_state_e es, input string tag);
    exp_t e;
    @(negedge clk);
    supply_ok = s; cm_ovr = ov; clip_neg = cn; clip_pos = cp;
    drive_lvl = lv; mod_bit = mb;
    @(posedge clk);
    e.d = ed; e.st = es; e.tag = tag;
    if (!s) begin
      e.v = 1'b0; up = 0;
    end else begin
      e.v = (up >= ASTART);
      if (up < ASTART) up++;
    end
    sb.push_back(e);
  endtask

  // Runs n edges of clipping, expecting the frame to begin at position 0.
  task automatic clip_run(input logic cn, input logic cp, input logic [1:0] lv,
                          input int run, input int n, input string tag);
    bit neg;
    mfs_state_e es;
    neg = cn;
    es  = cn ? ST_CLIP_NEG : ST_CLIP_POS;
    for (int i = 0; i < n; i++) begin
      int  p;
      logic tl;
      p  = i % (FILL + run);
      tl = (p >= FILL);
      step(1, 0, cn, cp, lv, 0, neg ? tl : !tl, es, tag);
    end
  endtask

  // Monitor: compare each produced bit against the scoreboard.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (dout !== e.d || state_dbg !== e.st) begin
        bad++;
        $display("FAIL %s: dout=%0b state=%0d expected dout=%0b state=%0d",
                 e.tag, dout, state_dbg, e.d, e.st);
      end
      total++;
      if (dout_valid !== e.v) begin
        bad++;
        $display("FAIL R11: dout_valid=%0b expected %0b (%s)", dout_valid, e.v, e.tag);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    total++;
    if (dout !== 1'b0 || state_dbg !== 3'd0 || dout_valid !== 1'b0) begin
      bad++;
      $display("FAIL R12: dout=%0b state=%0d valid=%0b expected 0/0/0",
               dout, state_dbg, dout_valid);
    end
    rst_n = 1'b1;

    // R1: supply missing, overvoltage also present
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, 1, 0, ST_NO_SUPPLY, "R1");
    // R3: startup pattern over overvoltage and clipping
    for (int i = 0; i < 32; i++) step(1, 1, 1, 0, 0, 1, i[0], ST_STARTUP, "R3");
    // R4: overvoltage over clipping; valid rises at bit 48
    for (int i = 0; i < 20; i++) step(1, 1, 1, 0, 0, 0, 1, ST_OVERVOLT, "R4");
    // R5: pass-through
    for (int i = 0; i < 40; i++) begin
      logic b;
      b = ((i * 5) % 3) == 0;
      step(1, 0, 0, 0, 0, b, b, ST_NORMAL, "R5");
    end
    // R6: negative clip, run 1, two frames
    clip_run(1, 0, 2'd0, 1, 2 * (FILL + 1), "R6");
    // R8: code 1 gives run 2 (frame continues aligned at position 0)
    clip_run(1, 0, 2'd1, 2, FILL + 2, "R8");
    // R10: both flags select negative, run 3
    clip_run(1, 1, 2'd2, 3, FILL + 3, "R10");
    // R7: positive clip, polarity change restarts frame, run 3
    clip_run(0, 1, 2'd2, 3, 2 * (FILL + 3), "R7");
    // R8: code 3 saturates at run 3
    clip_run(0, 1, 2'd3, 3, FILL + 3, "R8");
    // R9: mid-frame polarity change restarts at position 0
    clip_run(1, 0, 2'd0, 1, 50, "R9");
    clip_run(0, 1, 2'd0, 1, FILL + 1, "R9");
    // R9: entering clip from normal restarts
    step(1, 0, 0, 0, 0, 1, 1, ST_NORMAL, "R5");
    clip_run(1, 0, 2'd0, 1, 60, "R9");
    // R1: supply drop during clipping
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, 0, 0, ST_NO_SUPPLY, "R1");
    // R2: restart pattern with no faults
    for (int i = 0; i < 32; i++) step(1, 0, 0, 0, 0, 1, i[0], ST_STARTUP, "R2");
    for (int i = 0; i < 20; i++) step(1, 0, 0, 0, 0, i[1], i[1], ST_NORMAL, "R5");

    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule